// File: doc/BRIEF.md
# Software-Managed Variable-Page Translation Buffer

This block translates 32-bit effective addresses to physical addresses through a fully associative table of 64 entries. Software alone fills and maintains the table. Instruction fetches and data accesses share it. Each entry has two 32-bit words: a tag word and a data word. Software writes or reads either word by giving an entry index and a one-bit half select.

Each entry covers a page whose size it chooses for itself. The size runs from 1 KB to 16 MB in steps of four, so the number of address bits compared differs from entry to entry. A lookup names the kind of access. It returns a hit flag, the physical address, a 4-bit zone number and four cache-attribute bits. It also reports a miss, or a permission fault when a write or a fetch is not allowed. Software can invalidate every entry that matches an address, or clear the whole table in a single cycle.

Top module: `vpage_tlb`

## Requirements
- R1: Software writes the entry at `sw_idx` when `sw_we` is high. `sw_half`=0 selects the tag word and `sw_half`=1 selects the data word. A write affects lookups requested from the next cycle on, and not a lookup requested in the same cycle.
- R2: Tag word fields: bits 31:10 hold the effective page number, bits 9:7 hold the size code and bit 6 is the valid flag. When the tag word is read back, bits 5:0 read as zero.
- R3: Data word fields: bits 31:10 hold the real page number, bit 9 allows execution and bit 8 allows writes. Bits 7:4 hold the zone number and bits 3:0 hold the attributes: bit 3 write-through, bit 2 cache-inhibited, bit 1 coherent, bit 0 guarded. The data word reads back unchanged.
- R4: A size code s gives a page of 2^(10+2s) bytes, so codes 0 to 7 give 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M. Address bits below 10+2s are not compared. The physical address takes the real page number above that boundary and the effective address bits below it. Real-page-number bits below the boundary are ignored.
- R5: A lookup hits only on an entry whose valid flag is set and whose compared bits are equal. When several entries match, the lowest index supplies the result.
- R6: The result of a lookup requested on `lk_req` appears one cycle later, with `lk_valid` high. When `lk_valid` is low, the hit, miss and fault flags are low. On a miss the address, zone and attribute outputs are zero.
- R7: `lk_kind` is coded 0 for a read, 1 for a write, 2 for a fetch and 3 for a read. A write that hits an entry with the write bit clear raises `lk_wfault`. A fetch that hits an entry with the execute bit clear raises `lk_xfault`. Reads never fault. On a fault, `lk_hit` stays high and the translation is still returned.
- R8: `inv_one` clears the valid flag of every valid entry that matches `inv_ea` under that entry's own page size. Entries that do not match are left unchanged.
- R9: `inv_all` clears every valid flag at one clock edge, so a lookup requested in the next cycle misses.
- R10: A software read (`sw_re`) returns the selected word on `sw_rdata` one cycle later. `sw_rdata` holds its value when no read is made. After reset every entry is invalid and every word is zero.
- R11: When an invalidation and a tag write to the same entry happen in the same cycle, the written tag word takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_re | input | 1 | Software read strobe |
| sw_idx | input | 6 | Entry index |
| sw_half | input | 1 | 0 selects the tag word, 1 selects the data word |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, registered |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_valid | output | 1 | A lookup result is present |
| lk_hit | output | 1 | The lookup hit |
| lk_miss | output | 1 | The lookup missed |
| lk_wfault | output | 1 | A write hit a page that does not allow writes |
| lk_xfault | output | 1 | A fetch hit a page that does not allow execution |
| lk_pa | output | 32 | Physical address |
| lk_zone | output | 4 | Zone number of the hit entry |
| lk_attr | output | 4 | Cache attributes of the hit entry |
| inv_one | input | 1 | Invalidate the entries that match `inv_ea` |
| inv_ea | input | 32 | Address used by `inv_one` |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default parameters: 64 entries, a 32-bit address and a smallest page boundary at bit 10. With these values the whole range of size codes can be tested, from the 1 KB page to the 16 MB page that compares only eight bits. The top index 63 can also be written and translated. Overlapping entries of different sizes test lowest-index priority, and they show that invalidating by address uses each entry's own mask.

// File: rtl/vpage_tlb_pkg.sv
`timescale 1ns/1ps
package vpage_tlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   localparam int unsigned MASK_W = 64;

   // Ones on the address bits that are compared (and taken from the real page number)
   function automatic logic [MASK_W-1:0] keep_mask(input int unsigned lsb,
                                                   input int unsigned step,
                                                   input logic [7:0] code);
      logic [MASK_W-1:0] m;
      for (int unsigned b = 0; b < MASK_W; b++)
         m[b] = (b >= lsb + step * int'(code));
      return m;
   endfunction

endpackage

// File: rtl/vpage_tlb_entry.sv
`timescale 1ns/1ps
module vpage_tlb_entry
   import vpage_tlb_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned PG_LSB = 10,
   parameter int unsigned SZW    = 3,
   parameter int unsigned STEP   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_tag,
   input  logic          we_data,
   input  logic [AW-1:0] wdata,
   input  logic          inv_all,
   input  logic          inv_one,
   input  logic [AW-1:0] inv_ea,
   input  logic [AW-1:0] lk_ea,
   output logic          lk_match,
   output logic [SZW-1:0] pg_sz,
   output logic [AW-1:0] tag_word,
   output logic [AW-1:0] data_word
);
   localparam int unsigned VBIT  = PG_LSB - SZW - 1;
   localparam int unsigned SZ_HI = PG_LSB - 1;
   localparam int unsigned SZ_LO = PG_LSB - SZW;

   logic [AW-1:VBIT] tag_q;
   logic [AW-1:0]    data_q;
   logic [AW-1:0]    cmp_m;
   logic [MASK_W-1:0] full_m;
   logic             valid;
   logic             inv_hit;

   assign valid    = tag_q[VBIT];
   assign pg_sz    = tag_q[SZ_HI:SZ_LO];
   assign tag_word = {tag_q, {VBIT{1'b0}}};
   assign data_word = data_q;

   always_comb begin
      full_m = keep_mask(PG_LSB, STEP, 8'(pg_sz));
      cmp_m  = full_m[AW-1:0];
   end

   assign lk_match = valid && (((lk_ea  ^ tag_word) & cmp_m) == '0);
   assign inv_hit  = inv_one && valid && (((inv_ea ^ tag_word) & cmp_m) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         data_q <= '0;
      end else begin
         if (inv_all || inv_hit)
            tag_q[VBIT] <= 1'b0;
         if (we_tag)
            tag_q <= wdata[AW-1:VBIT];
         if (we_data)
            data_q <= wdata;
      end
   end
endmodule

// File: rtl/vpage_tlb_pick.sv
`timescale 1ns/1ps
module vpage_tlb_pick #(
   parameter int unsigned N  = 64,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  hits,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = int'(N) - 1; i >= 0; i--)
         if (hits[i])
            idx = i[IW-1:0];
      any = |hits;
   end
endmodule

// File: rtl/vpage_tlb.sv
`timescale 1ns/1ps
module vpage_tlb
   import vpage_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned AW      = 32,
   parameter int unsigned PG_LSB  = 10,
   parameter int unsigned SZW     = 3,
   parameter int unsigned STEP    = 2,
   parameter int unsigned IW      = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_we,
   input  logic          sw_re,
   input  logic [IW-1:0] sw_idx,
   input  logic          sw_half,
   input  logic [AW-1:0] sw_wdata,
   output logic [AW-1:0] sw_rdata,
   input  logic          lk_req,
   input  logic [AW-1:0] lk_ea,
   input  logic [1:0]    lk_kind,
   output logic          lk_valid,
   output logic          lk_hit,
   output logic          lk_miss,
   output logic          lk_wfault,
   output logic          lk_xfault,
   output logic [AW-1:0] lk_pa,
   output logic [3:0]    lk_zone,
   output logic [3:0]    lk_attr,
   input  logic          inv_one,
   input  logic [AW-1:0] inv_ea,
   input  logic          inv_all
);
   localparam int unsigned XBIT   = PG_LSB - 1;
   localparam int unsigned WBIT   = PG_LSB - 2;
   localparam int unsigned MAX_SH = PG_LSB + STEP * ((1 << SZW) - 1);

   // elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << IW) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PG_LSB < 10 || PG_LSB < SZW + 2) begin : g_bad_lsb
      $error("PG_LSB leaves no room for the tag and data fields");
   end
   if (MAX_SH >= AW || AW > MASK_W) begin : g_bad_aw
      $error("AW too small for the largest page or wider than the mask");
   end

   logic [ENTRIES-1:0] hit_v;
   logic [AW-1:0]      tag_w  [ENTRIES];
   logic [AW-1:0]      data_w [ENTRIES];
   logic [SZW-1:0]     sz_w   [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      vpage_tlb_entry #(
         .AW(AW), .PG_LSB(PG_LSB), .SZW(SZW), .STEP(STEP)
      ) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_tag    (sw_we && !sw_half && (sw_idx == IW'(e))),
         .we_data   (sw_we &&  sw_half && (sw_idx == IW'(e))),
         .wdata     (sw_wdata),
         .inv_all   (inv_all),
         .inv_one   (inv_one),
         .inv_ea    (inv_ea),
         .lk_ea     (lk_ea),
         .lk_match  (hit_v[e]),
         .pg_sz     (sz_w[e]),
         .tag_word  (tag_w[e]),
         .data_word (data_w[e])
      );
   end

   logic          any_hit;
   logic [IW-1:0] sel;

   vpage_tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick (
      .hits (hit_v),
      .any  (any_hit),
      .idx  (sel)
   );

   logic [AW-1:0]     sel_data;
   logic [MASK_W-1:0] sel_full_m;
   logic [AW-1:0]     sel_m;
   logic [AW-1:0]     pa_c;
   logic              wf_c, xf_c;

   always_comb begin
      sel_data   = data_w[sel];
      sel_full_m = keep_mask(PG_LSB, STEP, 8'(sz_w[sel]));
      sel_m      = sel_full_m[AW-1:0];
      pa_c       = (sel_data & sel_m) | (lk_ea & ~sel_m);
      wf_c       = (lk_kind == ACC_WRITE) && !sel_data[WBIT];
      xf_c       = (lk_kind == ACC_FETCH) && !sel_data[XBIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_valid  <= 1'b0;
         lk_hit    <= 1'b0;
         lk_miss   <= 1'b0;
         lk_wfault <= 1'b0;
         lk_xfault <= 1'b0;
         lk_pa     <= '0;
         lk_zone   <= '0;
         lk_attr   <= '0;
      end else begin
         lk_valid  <= lk_req;
         lk_hit    <= lk_req && any_hit;
         lk_miss   <= lk_req && !any_hit;
         lk_wfault <= lk_req && any_hit && wf_c;
         lk_xfault <= lk_req && any_hit && xf_c;
         lk_pa     <= (lk_req && any_hit) ? pa_c : '0;
         lk_zone   <= (lk_req && any_hit) ? sel_data[7:4] : '0;
         lk_attr   <= (lk_req && any_hit) ? sel_data[3:0] : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         sw_rdata <= '0;
      else if (sw_re)
         sw_rdata <= sw_half ? data_w[sw_idx] : tag_w[sw_idx];
   end
endmodule

// File: rtl/vpage_tlb_chk.sv
`timescale 1ns/1ps
module vpage_tlb_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sw_we,
   input logic          sw_re,
   input logic [AW-1:0] sw_rdata,
   input logic          lk_req,
   input logic [1:0]    lk_kind,
   input logic          lk_valid,
   input logic          lk_hit,
   input logic          lk_miss,
   input logic          lk_wfault,
   input logic          lk_xfault,
   input logic [AW-1:0] lk_pa,
   input logic          inv_all
);
   p_resp_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid);

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> (!lk_valid && !lk_hit && !lk_miss && !lk_wfault && !lk_xfault));

   p_hit_xor_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit != lk_miss));

   p_miss_zero_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (lk_pa == '0));

   p_fault_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_wfault || lk_xfault) |-> lk_hit);

   p_one_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_wfault, lk_xfault}));

   p_read_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && (lk_kind == 2'd0 || lk_kind == 2'd3)) |=> (!lk_wfault && !lk_xfault));

   p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !sw_we) ##1 lk_req |=> lk_miss);

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_re |=> $stable(sw_rdata));
endmodule

bind vpage_tlb vpage_tlb_chk #(.AW(AW)) u_vpage_tlb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sw_we     (sw_we),
   .sw_re     (sw_re),
   .sw_rdata  (sw_rdata),
   .lk_req    (lk_req),
   .lk_kind   (lk_kind),
   .lk_valid  (lk_valid),
   .lk_hit    (lk_hit),
   .lk_miss   (lk_miss),
   .lk_wfault (lk_wfault),
   .lk_xfault (lk_xfault),
   .lk_pa     (lk_pa),
   .inv_all   (inv_all)
);

// File: tb/test_vpage_tlb.sv
`timescale 1ns/1ps
module test_vpage_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_we = 1'b0, sw_re = 1'b0, sw_half = 1'b0;
   logic [5:0]  sw_idx = '0;
   logic [31:0] sw_wdata = '0, sw_rdata;
   logic        lk_req = 1'b0;
   logic [31:0] lk_ea = '0, lk_pa;
   logic [1:0]  lk_kind = '0;
   logic        lk_valid, lk_hit, lk_miss, lk_wfault, lk_xfault;
   logic [3:0]  lk_zone, lk_attr;
   logic        inv_one = 1'b0, inv_all = 1'b0;
   logic [31:0] inv_ea = '0;

   always #4 clk = ~clk;   // 125 MHz

   vpage_tlb i_vpage_tlb (.*);

   int n_vec = 0, n_bad = 0;
   logic [31:0] m_tag [64];
   logic [31:0] m_dat [64];
   logic [43:0] exp_q [$];
   string       tag_q [$];

   // {hit, miss, wfault, xfault, zone, attr, pa}
   function automatic logic [43:0] model(input logic [31:0] ea, input logic [1:0] k);
      for (int i = 0; i < 64; i++) begin
         if (m_tag[i][6]) begin
            logic [31:0] m;
            logic [31:0] d;
            m = ~((32'h1 << (10 + 2 * m_tag[i][9:7])) - 32'h1);
            if (((ea ^ m_tag[i]) & m) == 32'h0) begin
               d = m_dat[i];
               return {1'b1, 1'b0, (k == 2'd1) && !d[8], (k == 2'd2) && !d[9],
                       d[7:4], d[3:0], (d & m) | (ea & ~m)};
            end
         end
      end
      return {1'b0, 1'b1, 2'b00, 8'h00, 32'h0};
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && lk_valid) begin
         logic [43:0] act;
         act = {lk_hit, lk_miss, lk_wfault, lk_xfault, lk_zone, lk_attr, lk_pa};
         if (exp_q.size() == 0)
            check(1'b0, "R6 unexpected result", 64'(act), 64'h0);
         else begin
            logic [43:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(act == e, t, 64'(act), 64'(e));
         end
      end
   end

   task automatic sw_write(input int idx, input logic half, input logic [31:0] w);
      sw_we = 1'b1; sw_idx = 6'(idx); sw_half = half; sw_wdata = w;
      @(negedge clk);
      sw_we = 1'b0;
      if (half) m_dat[idx] = w; else m_tag[idx] = w;
   endtask

   task automatic look(input logic [31:0] ea, input logic [1:0] k, input string t);
      lk_req = 1'b1; lk_ea = ea; lk_kind = k;
      exp_q.push_back(model(ea, k)); tag_q.push_back(t);
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic sw_read(input int idx, input logic half, input logic [31:0] e,
                          input string t);
      sw_re = 1'b1; sw_idx = 6'(idx); sw_half = half;
      @(negedge clk);
      sw_re = 1'b0;
      check(sw_rdata == e, t, 64'(sw_rdata), 64'(e));
   endtask

   task automatic inv_addr(input logic [31:0] a);
      inv_one = 1'b1; inv_ea = a;
      @(negedge clk);
      inv_one = 1'b0;
      for (int i = 0; i < 64; i++) begin
         logic [31:0] m;
         m = ~((32'h1 << (10 + 2 * m_tag[i][9:7])) - 32'h1);
         if (m_tag[i][6] && (((a ^ m_tag[i]) & m) == 32'h0)) m_tag[i][6] = 1'b0;
      end
   endtask

   function automatic logic [31:0] tg(input logic [31:0] epn, input int sz);
      return (epn & 32'hFFFF_FC00) | (32'(sz) << 7) | 32'h40;
   endfunction

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_dat[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(lk_valid == 1'b0, "R10 reset lk_valid", 64'(lk_valid), 64'h0);
      check(sw_rdata == 32'h0, "R10 reset rdata", 64'(sw_rdata), 64'h0);
      sw_read(63, 1'b0, 32'h0, "R10 reset tag of entry 63");
      look(32'h0000_0000, 2'd0, "R10 lookup after reset misses");

      // fill entries
      sw_write(0, 1'b1, 32'h8000_0000 | 32'h300 | 32'h30 | 32'hA);
      sw_write(0, 1'b0, tg(32'h1000_0000, 1) | 32'h3F);
      sw_write(1, 1'b1, 32'h45AB_C000 | 32'h200 | 32'h50 | 32'h1);
      sw_write(1, 1'b0, tg(32'h2000_0000, 7));
      sw_write(2, 1'b1, 32'h0777_7C00 | 32'h100 | 32'h90 | 32'h4);
      sw_write(2, 1'b0, tg(32'h2012_3000, 0));
      sw_write(10, 1'b1, 32'h0BBB_B000 | 32'h300 | 32'h20 | 32'h2);
      sw_write(10, 1'b0, tg(32'h2012_3000, 0));
      sw_write(63, 1'b1, 32'h9000_03FF);
      sw_write(63, 1'b0, tg(32'h3000_0000, 3));
      sw_write(40, 1'b1, 32'h1111_1300);
      sw_write(40, 1'b0, 32'h5000_0000);   // valid flag clear

      // R2/R3 readback
      sw_read(0, 1'b0, tg(32'h1000_0000, 1), "R2 tag readback low bits zero");
      sw_read(1, 1'b1, 32'h45AB_C250 | 32'h1, "R3 data readback");

      // R4: page sizes and pass-through
      look(32'h1000_0ABC, 2'd0, "R4 4K page inside");
      look(32'h1000_1ABC, 2'd0, "R4 4K page outside misses");
      look(32'h20FF_FFFC, 2'd2, "R4 16M page ignores low real page bits");
      look(32'h3000_FFFF, 2'd1, "R4 64K page top offset");
      look(32'h3001_0000, 2'd0, "R4 64K page next misses");
      // R5: invalid entry, overlap priority
      look(32'h5000_0000, 2'd0, "R5 invalid entry misses");
      look(32'h2012_3004, 2'd0, "R5 lowest index wins overlap");
      // R7: faults
      look(32'h2012_3004, 2'd1, "R7 write to no-write page faults");
      look(32'h2012_3004, 2'd3, "R7 kind 3 acts as read");
      look(32'h1000_0000, 2'd2, "R7 fetch allowed");
      // R8: invalidate the 16M entry by address
      inv_addr(32'h2080_0000);
      look(32'h2012_33FF, 2'd2, "R8 entry 2 uncovered, fetch faults");
      look(32'h2012_33FF, 2'd1, "R7 write allowed on entry 2");
      look(32'h20FF_0000, 2'd0, "R8 16M entry gone");
      inv_addr(32'h2012_3123);
      look(32'h2012_3000, 2'd0, "R8 all matching entries cleared");
      look(32'h1000_0004, 2'd0, "R8 other entry kept");
      drain();

      // R1: same-cycle write is not seen
      sw_write(20, 1'b1, 32'h0CCC_C000 | 32'h300 | 32'hE0 | 32'h8);
      sw_we = 1'b1; sw_idx = 6'd20; sw_half = 1'b0; sw_wdata = tg(32'h6000_0000, 0);
      lk_req = 1'b1; lk_ea = 32'h6000_0010; lk_kind = 2'd0;
      exp_q.push_back(model(32'h6000_0010, 2'd0)); tag_q.push_back("R1 same-cycle write not seen");
      @(negedge clk);
      sw_we = 1'b0; lk_req = 1'b0;
      m_tag[20] = tg(32'h6000_0000, 0);
      look(32'h6000_0010, 2'd0, "R1 write seen next cycle");

      // R11 + R9: flush with simultaneous tag write
      sw_write(5, 1'b1, 32'h0DDD_D000 | 32'h300 | 32'h70 | 32'h3);
      inv_all = 1'b1;
      sw_we = 1'b1; sw_idx = 6'd5; sw_half = 1'b0; sw_wdata = tg(32'h7000_0000, 2);
      @(negedge clk);
      inv_all = 1'b0; sw_we = 1'b0;
      for (int i = 0; i < 64; i++) m_tag[i][6] = 1'b0;
      m_tag[5] = tg(32'h7000_0000, 2);
      look(32'h3000_FFFF, 2'd0, "R9 flushed entry misses");
      look(32'h6000_0010, 2'd0, "R9 flushed entry misses");
      look(32'h7000_3FFF, 2'd1, "R11 tag written with flush survives");
      drain();
      check(exp_q.size() == 0, "R6 every request answered", 64'(exp_q.size()), 64'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #800000;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule